// File: doc/BRIEF.md
# Serial Host Command Decoder and Register Bank

This block is the host-facing serial slave of a receiver for an avionics data bus. A host drives a four-wire SPI link (clock, active-low select, data in, data out). Each transaction begins with an 8-bit command byte, most significant bit first. The command byte then sets how many data bits follow and which way they travel. The number of data bits can be zero, eight, sixteen, thirty-two, two hundred fifty-six, or an open-ended stream of receive words. All pin inputs are resynchronised into the system clock domain, and every action is taken on edges detected there.

The block holds the receiver configuration: a 16-bit control word, an 8-bit clock-divide value, and a 256-entry table that enables or disables each label. The host can stream the whole table in a single transfer, or set or clear every entry with a one-byte command. The block also issues a master-reset pulse that clears the receive FIFO. On the read side it serialises the FIFO status byte, the stored registers, the label table, and receive words. A receive word leaves the FIFO only after all of its bits have been shifted out.

Top module: `hsi_regbank`

## Requirements
- R1: After reset, `ctrl_reg`, `clk_div` and `label_en` are all zero, and `so`, `fifo_pop` and `mreset` are low.
- R2: Command 0x10 followed by 16 data bits loads `ctrl_reg`, first bit into bit 15. Command 0x0B shifts `ctrl_reg` out on `so`, bit 15 first. Each read bit is driven after a falling SCK edge and is valid at the next rising edge; the first one follows the eighth command bit.
- R3: Command 0x01, once its eighth bit is taken and while select is still low, raises `mreset` for exactly one system clock and clears `ctrl_reg` to zero.
- R4: Command 0x02 clears all 256 `label_en` bits. Command 0x03 sets all of them.
- R5: Command 0x06 takes 256 data bits. Data bit k sets `label_en[255-k]`, so the first bit programs label 255 and the last programs label 0. Command 0x0D returns the table in the same order, label 255 first.
- R6: Command 0x07 loads the 8-bit `clk_div` value, MSB first. Command 0x0C returns it, MSB first.
- R7: Command 0x08 shifts out the head receive word, bit 31 first, and pulses `fifo_pop` for one cycle once its 32nd bit has been clocked. If the FIFO is empty the command returns zeros and does not pop. A read cut short before the 32nd bit does not pop.
- R8: Command 0x09 streams receive words back to back, popping each one after its 32nd bit. Once the FIFO is drained it returns zeros.
- R9: Command 0x0A returns a status byte, MSB first. Bit 0 is FIFO empty, bit 1 is FIFO half full (16 or more words), bit 2 is FIFO full, and bits 7..3 read as zero.
- R10: Raising select before a register write has received all of its data bits abandons the write, and the register keeps its old value.
- R11: Commands 0x00, 0x04, 0x05, 0x0E and 0x0F change no register and drive `so` low for all data bits that follow.
- R12: `so` is low whenever select has been high for several system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host (asynchronous) |
| cs_n | input | 1 | Active-low select from host (asynchronous) |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host |
| fifo_rd_data | input | 32 | Head word of the receive FIFO (valid when not empty) |
| fifo_empty | input | 1 | Receive FIFO holds no word |
| fifo_half | input | 1 | Receive FIFO holds 16 or more words |
| fifo_full | input | 1 | Receive FIFO is full |
| fifo_pop | output | 1 | One-cycle request to remove the head word |
| mreset | output | 1 | One-cycle master reset pulse to the receive path |
| ctrl_reg | output | 16 | Control word |
| clk_div | output | 8 | Clock-divide value |
| label_en | output | 256 | Label enable table, bit n for label n |

## Verification
The assertions assume that each SCK level is held for several system clocks, so that every synchronised edge is seen once, and that SI is stable around each rising SCK edge. They also assume that the FIFO word count falls only through `fifo_pop` or `mreset`, and that `fifo_rd_data` is valid whenever `fifo_empty` is low. Under those conditions a pop can never hit an empty FIFO. The bench keeps each SCK half period at eight system clocks and changes SI only while SCK is low. Its FIFO model adds words only while select is high and removes them only on a pop or a master reset.

// File: rtl/hsi_pkg.sv
package hsi_pkg;

    // command byte values
    localparam logic [7:0] OP_MRST    = 8'h01;
    localparam logic [7:0] OP_LCLR    = 8'h02;
    localparam logic [7:0] OP_LSET    = 8'h03;
    localparam logic [7:0] OP_LWR     = 8'h06;
    localparam logic [7:0] OP_DIVWR   = 8'h07;
    localparam logic [7:0] OP_RDWORD  = 8'h08;
    localparam logic [7:0] OP_DUMP    = 8'h09;
    localparam logic [7:0] OP_RDSTAT  = 8'h0A;
    localparam logic [7:0] OP_RDCTRL  = 8'h0B;
    localparam logic [7:0] OP_RDDIV   = 8'h0C;
    localparam logic [7:0] OP_RDLBL   = 8'h0D;
    localparam logic [7:0] OP_CTRLWR  = 8'h10;

    typedef enum logic {
        PH_OPC  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       full;
        logic       half;
        logic       empty;
    } stat_t;

    function automatic stat_t make_stat(input logic e, input logic h, input logic f);
        stat_t s;
        s.rsvd  = '0;
        s.full  = f;
        s.half  = h;
        s.empty = e;
        return s;
    endfunction

    function automatic logic is_word_read(input logic [7:0] op);
        return (op == OP_RDWORD) || (op == OP_DUMP);
    endfunction

endpackage

// File: rtl/hsi_pin_sync.sv
module hsi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_pin,
    input  logic csn_pin,
    input  logic si_pin,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic si_s
);
    // packed lane order: {si, cs_n, sck}
    localparam logic [2:0] IDLE_VAL = 3'b010;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            logic [2:0] q;
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) q <= IDLE_VAL;
                    else     q <= {si_pin, csn_pin, sck_pin};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) q <= IDLE_VAL;
                    else     q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    logic [2:0] last;
    logic       sck_d;

    assign last = g_stage[STAGES-1].q;

    always_ff @(posedge clk) begin
        if (rst) sck_d <= 1'b0;
        else     sck_d <= last[0];
    end

    assign sck_rise = last[0] & ~sck_d;
    assign sck_fall = ~last[0] & sck_d;
    assign cs_act   = ~last[1];
    assign si_s     = last[2];
endmodule

// File: rtl/hsi_label_map.sv
module hsi_label_map #(
    parameter  int NUM = 256,
    localparam int AW  = $clog2(NUM)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           set_all,
    input  logic           clr_all,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_idx,
    input  logic           wr_val,
    output logic [NUM-1:0] map
);
    generate
        for (genvar g = 0; g < NUM; g++) begin : g_ent
            logic q;
            always_ff @(posedge clk) begin
                if (rst || clr_all)                   q <= 1'b0;
                else if (set_all)                     q <= 1'b1;
                else if (wr_en && wr_idx == AW'(g))   q <= wr_val;
            end
            assign map[g] = q;
        end
    endgenerate
endmodule

// File: rtl/hsi_cmd_engine.sv
module hsi_cmd_engine
    import hsi_pkg::*;
#(
    parameter  int CTRL_W  = 16,
    parameter  int DIV_W   = 8,
    parameter  int NUM     = 256,
    parameter  int WORD_W  = 32,
    localparam int LBL_AW  = $clog2(NUM),
    localparam int CNT_W   = LBL_AW + 1,
    localparam int CTRL_AW = $clog2(CTRL_W),
    localparam int DIV_AW  = $clog2(DIV_W),
    localparam int WORD_AW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_act,
    input  logic              si_s,
    input  logic [WORD_W-1:0] fifo_rd_data,
    input  logic              fifo_empty,
    input  stat_t             stat,
    input  logic [NUM-1:0]    labels,
    output logic              so,
    output logic              fifo_pop,
    output logic              mreset,
    output logic              lbl_set,
    output logic              lbl_clr,
    output logic              lbl_we,
    output logic [LBL_AW-1:0] lbl_idx,
    output logic              lbl_val,
    output logic [CTRL_W-1:0] ctrl_reg,
    output logic [DIV_W-1:0]  clk_div
);
    phase_e              phase;
    logic [7:0]          opsr;
    logic [2:0]          opcnt;
    logic [7:0]          op_q;
    logic [CNT_W-1:0]    dcnt;
    logic [WORD_AW-1:0]  wbit;
    logic [CTRL_W-1:0]   wsr;
    logic [WORD_W-1:0]   rx_word;
    logic                live;
    logic                pend1, pend2;
    logic                rd_bit;
    logic [7:0]          new_op;
    logic [7:0]          stat_v;

    assign new_op = {opsr[6:0], si_s};
    assign stat_v = stat;

    // bit presented for the current data position
    always_comb begin
        rd_bit = 1'b0;
        case (op_q)
            OP_RDCTRL: if (dcnt < CNT_W'(CTRL_W))
                rd_bit = ctrl_reg[CTRL_AW'(CTRL_W-1) - dcnt[CTRL_AW-1:0]];
            OP_RDDIV:  if (dcnt < CNT_W'(DIV_W))
                rd_bit = clk_div[DIV_AW'(DIV_W-1) - dcnt[DIV_AW-1:0]];
            OP_RDSTAT: if (dcnt < CNT_W'(8))
                rd_bit = stat_v[3'd7 - dcnt[2:0]];
            OP_RDLBL:  if (dcnt < CNT_W'(NUM))
                rd_bit = labels[LBL_AW'(NUM-1) - dcnt[LBL_AW-1:0]];
            OP_RDWORD, OP_DUMP:
                rd_bit = rx_word[WORD_AW'(WORD_W-1) - wbit];
            default: rd_bit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_OPC;
            opsr     <= '0;
            opcnt    <= '0;
            op_q     <= '0;
            dcnt     <= '0;
            wbit     <= '0;
            wsr      <= '0;
            rx_word  <= '0;
            live     <= 1'b0;
            pend1    <= 1'b0;
            pend2    <= 1'b0;
            so       <= 1'b0;
            fifo_pop <= 1'b0;
            mreset   <= 1'b0;
            lbl_set  <= 1'b0;
            lbl_clr  <= 1'b0;
            lbl_we   <= 1'b0;
            lbl_idx  <= '0;
            lbl_val  <= 1'b0;
            ctrl_reg <= '0;
            clk_div  <= '0;
        end else begin
            fifo_pop <= 1'b0;
            mreset   <= 1'b0;
            lbl_set  <= 1'b0;
            lbl_clr  <= 1'b0;
            lbl_we   <= 1'b0;
            pend1    <= 1'b0;
            pend2    <= pend1;

            if (!cs_act) begin
                phase <= PH_OPC;
                opcnt <= '0;
                dcnt  <= '0;
                wbit  <= '0;
                so    <= 1'b0;
                op_q  <= '0;
            end else begin
                if (sck_rise) begin
                    if (phase == PH_OPC) begin
                        opsr  <= new_op;
                        opcnt <= opcnt + 3'd1;
                        if (opcnt == 3'd7) begin
                            phase <= PH_DATA;
                            op_q  <= new_op;
                            dcnt  <= '0;
                            wbit  <= '0;
                            case (new_op)
                                OP_MRST: begin
                                    mreset   <= 1'b1;
                                    ctrl_reg <= '0;
                                    live     <= 1'b0;
                                    rx_word  <= '0;
                                end
                                OP_LCLR: lbl_clr <= 1'b1;
                                OP_LSET: lbl_set <= 1'b1;
                                default: ;
                            endcase
                            if (is_word_read(new_op)) begin
                                rx_word <= fifo_empty ? '0 : fifo_rd_data;
                                live    <= ~fifo_empty;
                            end
                        end
                    end else begin
                        if (dcnt != '1) dcnt <= dcnt + 1'b1;
                        wbit <= wbit + 1'b1;
                        wsr  <= {wsr[CTRL_W-2:0], si_s};
                        case (op_q)
                            OP_CTRLWR: if (dcnt == CNT_W'(CTRL_W-1))
                                ctrl_reg <= {wsr[CTRL_W-2:0], si_s};
                            OP_DIVWR:  if (dcnt == CNT_W'(DIV_W-1))
                                clk_div <= {wsr[DIV_W-2:0], si_s};
                            OP_LWR: if (dcnt < CNT_W'(NUM)) begin
                                lbl_we  <= 1'b1;
                                lbl_idx <= LBL_AW'(NUM-1) - dcnt[LBL_AW-1:0];
                                lbl_val <= si_s;
                            end
                            OP_RDWORD, OP_DUMP: if (wbit == '1 && live) begin
                                fifo_pop <= 1'b1;
                                live     <= 1'b0;
                                rx_word  <= '0;
                                pend1    <= (op_q == OP_DUMP);
                            end
                            default: ;
                        endcase
                    end
                end
                if (sck_fall) so <= (phase == PH_DATA) ? rd_bit : 1'b0;
                if (pend2) begin
                    rx_word <= fifo_empty ? '0 : fifo_rd_data;
                    live    <= ~fifo_empty;
                end
            end
        end
    end
endmodule

// File: rtl/hsi_regbank.sv
module hsi_regbank
    import hsi_pkg::*;
#(
    parameter int CTRL_W      = 16,
    parameter int DIV_W       = 8,
    parameter int NUM_LABELS  = 256,
    parameter int WORD_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sck,
    input  logic                  cs_n,
    input  logic                  si,
    output logic                  so,
    input  logic [WORD_W-1:0]     fifo_rd_data,
    input  logic                  fifo_empty,
    input  logic                  fifo_half,
    input  logic                  fifo_full,
    output logic                  fifo_pop,
    output logic                  mreset,
    output logic [CTRL_W-1:0]     ctrl_reg,
    output logic [DIV_W-1:0]      clk_div,
    output logic [NUM_LABELS-1:0] label_en
);
    localparam int LBL_AW = $clog2(NUM_LABELS);

    logic              sck_rise, sck_fall, cs_act, si_s;
    logic              lbl_set, lbl_clr, lbl_we, lbl_val;
    logic [LBL_AW-1:0] lbl_idx;
    stat_t             stat;

    assign stat = make_stat(fifo_empty, fifo_half, fifo_full);

    hsi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sck_pin(sck), .csn_pin(cs_n), .si_pin(si),
        .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_act(cs_act), .si_s(si_s)
    );

    hsi_cmd_engine #(
        .CTRL_W(CTRL_W), .DIV_W(DIV_W), .NUM(NUM_LABELS), .WORD_W(WORD_W)
    ) u_eng (
        .clk(clk), .rst(rst),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act), .si_s(si_s),
        .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
        .stat(stat), .labels(label_en),
        .so(so), .fifo_pop(fifo_pop), .mreset(mreset),
        .lbl_set(lbl_set), .lbl_clr(lbl_clr), .lbl_we(lbl_we),
        .lbl_idx(lbl_idx), .lbl_val(lbl_val),
        .ctrl_reg(ctrl_reg), .clk_div(clk_div)
    );

    hsi_label_map #(.NUM(NUM_LABELS)) u_map (
        .clk(clk), .rst(rst),
        .set_all(lbl_set), .clr_all(lbl_clr),
        .wr_en(lbl_we), .wr_idx(lbl_idx), .wr_val(lbl_val),
        .map(label_en)
    );
endmodule

// File: rtl/hsi_regbank_chk.sv
module hsi_regbank_chk #(
    parameter int CTRL_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              so,
    input logic              fifo_empty,
    input logic              fifo_pop,
    input logic              mreset,
    input logic [CTRL_W-1:0] ctrl_reg
);
    logic [2:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst)            idle_cnt <= '0;
        else if (!cs_n)     idle_cnt <= '0;
        else if (idle_cnt != 3'd7) idle_cnt <= idle_cnt + 3'd1;
    end

    assert_pop_single_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);

    assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);

    assert_mrst_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        mreset |=> !mreset);

    assert_mrst_ctrl_R3: assert property (@(posedge clk) disable iff (rst)
        mreset |-> (ctrl_reg == '0));

    assert_so_idle_R12: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt >= 3'd4) |-> !so);
endmodule

bind hsi_regbank hsi_regbank_chk #(.CTRL_W(CTRL_W)) u_chk (.*);

// File: tb/sim_hsi_regbank.sv
module sim_hsi_regbank;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sck = 1'b0;
    logic         cs_n = 1'b1;
    logic         si = 1'b0;
    logic         so;
    logic [31:0]  fifo_rd_data;
    logic         fifo_empty, fifo_half, fifo_full;
    logic         fifo_pop, mreset;
    logic [15:0]  ctrl_reg;
    logic [7:0]   clk_div;
    logic [255:0] label_en;

    always #5 clk = ~clk;

    hsi_regbank u0 (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
        .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty),
        .fifo_half(fifo_half), .fifo_full(fifo_full),
        .fifo_pop(fifo_pop), .mreset(mreset),
        .ctrl_reg(ctrl_reg), .clk_div(clk_div), .label_en(label_en)
    );

    // receive FIFO model
    logic [31:0] fq[$];
    int          fcnt = 0;
    logic [31:0] fhead = '0;
    int          pop_cnt = 0;
    int          mr_cnt = 0;

    always @(posedge clk) begin
        if (mreset) fq.delete();
        else if (fifo_pop && fq.size() > 0) void'(fq.pop_front());
        fcnt  <= fq.size();
        fhead <= (fq.size() > 0) ? fq[0] : 32'h0;
        if (fifo_pop) pop_cnt <= pop_cnt + 1;
        if (mreset)   mr_cnt  <= mr_cnt + 1;
    end

    assign fifo_empty   = (fcnt == 0);
    assign fifo_half    = (fcnt >= 16);
    assign fifo_full    = (fcnt >= 32);
    assign fifo_rd_data = fhead;

    // scoreboard
    int n_run = 0;
    int n_fail = 0;
    typedef struct { logic [255:0] v; string tag; } exp_t;
    exp_t         exp_q[$];
    logic [255:0] act_q[$];
    exp_t         m_e;
    logic [255:0] m_a;

    task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            m_e = exp_q.pop_front();
            m_a = act_q.pop_front();
            check(m_e.tag, m_a, m_e.v);
        end
    end

    task automatic expect_rd(input string tag, input logic [255:0] v);
        exp_t e;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic xfer(input logic [7:0] op, input logic [255:0] wd,
                        input int nb, input bit cap);
        logic [255:0] rd;
        rd = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 8 + nb; i++) begin
            si = (i < 8) ? op[7-i] : wd[nb-1-(i-8)];
            repeat (8) @(negedge clk);
            if (i >= 8) rd = {rd[254:0], so};
            sck = 1'b1;
            repeat (8) @(negedge clk);
            sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        si   = 1'b0;
        repeat (10) @(negedge clk);
        if (cap) act_q.push_back(rd);
    endtask

    logic [255:0] lbl_vec;
    int           pc0, mc0;

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int l = 0; l < 256; l++) lbl_vec[l] = l[0] ^ l[2] ^ l[5];

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R1 reset state
        check("R1 ctrl_reg", 256'(ctrl_reg), 256'h0);
        check("R1 clk_div", 256'(clk_div), 256'h0);
        check("R1 label_en", label_en, 256'h0);
        check("R1 so/pop/mreset", 256'({so, fifo_pop, mreset}), 256'h0);

        // R2 control write and readback
        xfer(8'h10, 256'h0000_A5C3, 16, 0);
        check("R2 ctrl write", 256'(ctrl_reg), 256'hA5C3);
        expect_rd("R2 ctrl readback", 256'hA5C3);
        xfer(8'h0B, '0, 16, 1);

        // R10 aborted write leaves register untouched
        xfer(8'h10, 256'h3FF, 10, 0);
        check("R10 aborted ctrl write", 256'(ctrl_reg), 256'hA5C3);
        xfer(8'h07, 256'h5, 4, 0);
        check("R10 aborted div write", 256'(clk_div), 256'h0);

        // R6 divide value
        xfer(8'h07, 256'h0A, 8, 0);
        check("R6 div write", 256'(clk_div), 256'h0A);
        expect_rd("R6 div readback", 256'h0A);
        xfer(8'h0C, '0, 8, 1);

        // R4 set all / clear all
        xfer(8'h03, '0, 0, 0);
        check("R4 set all", label_en, {256{1'b1}});
        xfer(8'h02, '0, 0, 0);
        check("R4 clear all", label_en, 256'h0);

        // R5 streamed table, descending label order
        xfer(8'h06, lbl_vec, 256, 0);
        check("R5 table write", label_en, lbl_vec);
        expect_rd("R5 table readback", lbl_vec);
        xfer(8'h0D, '0, 256, 1);

        // R11 inert commands
        expect_rd("R11 op 0E so low", 256'h0);
        xfer(8'h0E, 256'hFFFF, 16, 1);
        expect_rd("R11 op 04 so low", 256'h0);
        xfer(8'h04, 256'hFF, 8, 1);
        xfer(8'h00, 256'hFF, 8, 0);
        xfer(8'h05, 256'hFF, 8, 0);
        xfer(8'h0F, 256'hFF, 8, 0);
        check("R11 ctrl unchanged", 256'(ctrl_reg), 256'hA5C3);
        check("R11 div unchanged", 256'(clk_div), 256'h0A);
        check("R11 table unchanged", label_en, lbl_vec);

        // R12 idle output
        check("R12 so idle", 256'(so), 256'h0);

        // R9 status empty
        expect_rd("R9 status empty", 256'h01);
        xfer(8'h0A, '0, 8, 1);

        // R7 single word reads
        fq.push_back(32'hDEAD_BEEF);
        fq.push_back(32'h1234_5678);
        fq.push_back(32'h8000_0001);
        repeat (4) @(negedge clk);
        expect_rd("R7 word 0", 256'hDEAD_BEEF);
        xfer(8'h08, '0, 32, 1);
        pc0 = pop_cnt;
        xfer(8'h08, '0, 20, 0);
        check("R7 partial read no pop", 256'(pop_cnt - pc0), 256'h0);
        expect_rd("R7 word 1 after partial", 256'h1234_5678);
        xfer(8'h08, '0, 32, 1);
        expect_rd("R7 word 2", 256'h8000_0001);
        xfer(8'h08, '0, 32, 1);
        pc0 = pop_cnt;
        expect_rd("R7 empty reads zero", 256'h0);
        xfer(8'h08, '0, 32, 1);
        check("R7 empty no pop", 256'(pop_cnt - pc0), 256'h0);

        // R8 dump
        fq.push_back(32'hCAFE_0001);
        fq.push_back(32'h0BAD_F00D);
        fq.push_back(32'h7777_AAAA);
        repeat (4) @(negedge clk);
        expect_rd("R8 dump stream", 256'hCAFE_0001_0BAD_F00D_7777_AAAA_0000_0000);
        xfer(8'h09, '0, 128, 1);
        check("R8 dump pop count", 256'(fq.size()), 256'h0);

        // R9 half and full flags
        for (int k = 0; k < 16; k++) fq.push_back(32'(k));
        repeat (4) @(negedge clk);
        expect_rd("R9 status half", 256'h02);
        xfer(8'h0A, '0, 8, 1);
        for (int k = 0; k < 16; k++) fq.push_back(32'(k + 100));
        repeat (4) @(negedge clk);
        expect_rd("R9 status full", 256'h06);
        xfer(8'h0A, '0, 8, 1);

        // R3 master reset
        mc0 = mr_cnt;
        xfer(8'h01, '0, 0, 0);
        check("R3 single mreset pulse", 256'(mr_cnt - mc0), 256'h1);
        check("R3 ctrl cleared", 256'(ctrl_reg), 256'h0);
        expect_rd("R3 fifo cleared status", 256'h01);
        xfer(8'h0A, '0, 8, 1);

        repeat (20) @(negedge clk);
        check("scoreboard drained", 256'(exp_q.size() + act_q.size()), 256'h0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule